// File: doc/BRIEF.md
# Exception Entry Selector

This block decides which pending exception a processor core enters, and produces all the state changes that entry requires, in a single registered step. Seven sources can request entry: reset, undefined instruction, software interrupt, prefetch abort, data abort, normal interrupt and fast interrupt. When several sources are pending at once, the block picks one by fixed precedence. It then emits the new status word, a saved copy of the old status word, the return link value for the target mode, the target mode code and the vector address to fetch from.

Requests that come from an executing instruction count only when the execute stage reports a live instruction. A fetch abort on an instruction that was squashed by a taken branch therefore does nothing. The two interrupt inputs count only at an instruction boundary and only while their mask bit in the current status word is clear. The vector base is either all zeros or a configurable high base. Bit 9 of the new status word comes from a configuration input. Exception return, the banked register file and decode belong to neighbouring blocks.

Top module: `exc_entry_ctrl`

## Requirements
- R1: While `rstN` is low, `entryValid` and every data output are zero.
- R2: Precedence, highest first, is reset, data abort, fast interrupt, normal interrupt, prefetch abort, undefined instruction, software interrupt. Exactly one entry is taken per cycle.
- R3: `vectorAddr` is the base OR an offset. The offset is 0x00 for reset, 0x04 for undefined, 0x08 for software interrupt, 0x0C for prefetch abort, 0x10 for data abort, 0x18 for normal interrupt and 0x1C for fast interrupt. The base is 0 when `highVec` is low and 0xFFFF0000 when it is high.
- R4: `targetMode` and `newStatus[4:0]` carry the mode code of the entry: 0b10011 for reset and software interrupt, 0b11011 for undefined, 0b10111 for both aborts, 0b10010 for normal interrupt and 0b10001 for fast interrupt.
- R5: On every entry, `newStatus` is `curStatus` with these changes: bit 5 cleared, bit 7 set, and bit 9 taken from `endianOnEntry`. Bits 31:10 are copied from `curStatus`.
- R6: Bit 6 of `newStatus` is set on reset and fast-interrupt entry. On every other entry it copies `curStatus[6]`.
- R7: Bit 8 of `newStatus` is set on reset, both aborts and both interrupts. On undefined and software-interrupt entry it copies `curStatus[8]`.
- R8: `linkAddr` is one of the following: `curAddr`+4 for undefined, software interrupt and prefetch abort; `curAddr`+8 for data abort; `nextAddr`+4 for both interrupts.
- R9: `savedStatus` receives `curStatus` on every entry except reset. On reset entry, `savedStatus` and `linkAddr` keep their previous values.
- R10: The normal interrupt is taken only when `atBoundary` is high and `curStatus[7]` is low. The fast interrupt is taken only when `atBoundary` is high and `curStatus[6]` is low.
- R11: Undefined, software-interrupt and prefetch-abort requests are ignored unless `execValid` is high.
- R12: Outputs are registered. `entryValid` is high for exactly the cycle after an accepted request, and all outputs hold when no entry is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset of the block's registers |
| resetReq | input | 1 | Reset exception request |
| undefReq | input | 1 | Undefined instruction in execute |
| swiReq | input | 1 | Software interrupt instruction in execute |
| pabortReq | input | 1 | Instruction in execute carries a fetch abort flag |
| dabortReq | input | 1 | Data access aborted by memory |
| irqReq | input | 1 | Normal interrupt line |
| fiqReq | input | 1 | Fast interrupt line |
| execValid | input | 1 | Instruction in execute is live (not squashed) |
| atBoundary | input | 1 | Current cycle is an instruction boundary |
| curStatus | input | 32 | Current status word |
| curAddr | input | 32 | Address of the instruction in execute |
| nextAddr | input | 32 | Address of the next instruction to execute |
| highVec | input | 1 | Select the high vector base |
| endianOnEntry | input | 1 | Value loaded into status bit 9 on entry |
| entryValid | output | 1 | One-cycle entry strobe |
| newStatus | output | 32 | Status word for the target mode |
| savedStatus | output | 32 | Copy of the old status word |
| linkAddr | output | 32 | Return link value for the target mode |
| targetMode | output | 5 | Mode code of the entry |
| vectorAddr | output | 32 | Vector address to fetch from |

## Verification
Some properties are checked on every clock cycle. Every entry must set the normal-interrupt mask and clear bit 5. The mode code must be a legal one, and the vector upper half must follow the high-vector input. The fast-interrupt mask must copy the old value for entries outside supervisor and fast-interrupt mode. An unmasked fast interrupt at a boundary with no higher source must be taken. A cycle with no qualified request must produce no strobe, and the outputs must hold between entries.

Other behaviours need the bench's scenarios and its per-cycle reference model. These are the full precedence chain with several requests active together, the exact link offsets, the saved status and link values being kept across a reset entry, and squashed fetch aborts leaving the outputs untouched.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

  typedef enum logic [2:0] {
    EXC_RESET = 3'd0,
    EXC_UNDEF = 3'd1,
    EXC_SWI   = 3'd2,
    EXC_PABT  = 3'd3,
    EXC_DABT  = 3'd4,
    EXC_IRQ   = 3'd5,
    EXC_FIQ   = 3'd6
  } excKind_e;

  // Mode codes written into status[4:0]
  localparam logic [4:0] MODE_SVC = 5'b10011;
  localparam logic [4:0] MODE_UND = 5'b11011;
  localparam logic [4:0] MODE_ABT = 5'b10111;
  localparam logic [4:0] MODE_IRQ = 5'b10010;
  localparam logic [4:0] MODE_FIQ = 5'b10001;

  // Status bit positions
  localparam int unsigned BIT_TSTATE = 5;
  localparam int unsigned BIT_FMASK  = 6;
  localparam int unsigned BIT_IMASK  = 7;
  localparam int unsigned BIT_AMASK  = 8;
  localparam int unsigned BIT_ENDIAN = 9;

  // Strobes from control to datapath
  typedef struct packed {
    logic     take;
    excKind_e kind;
  } ctrlStrobe_t;

endpackage

// File: rtl/exc_entry_sel.sv
module exc_entry_sel
  import exc_entry_pkg::*;
(
  input  logic        resetReq,
  input  logic        undefReq,
  input  logic        swiReq,
  input  logic        pabortReq,
  input  logic        dabortReq,
  input  logic        irqReq,
  input  logic        fiqReq,
  input  logic        execValid,
  input  logic        atBoundary,
  input  logic        irqMasked,
  input  logic        fiqMasked,
  output ctrlStrobe_t strobe
);

  logic fiqLive;
  logic irqLive;
  logic pabtLive;
  logic undefLive;
  logic swiLive;

  always_comb begin
    fiqLive   = fiqReq && atBoundary && !fiqMasked;
    irqLive   = irqReq && atBoundary && !irqMasked;
    pabtLive  = pabortReq && execValid;
    undefLive = undefReq && execValid;
    swiLive   = swiReq && execValid;
  end

  // Fixed precedence: reset, data abort, fiq, irq, prefetch abort, undef, swi
  always_comb begin
    strobe.take = 1'b1;
    strobe.kind = EXC_RESET;
    if (resetReq)       strobe.kind = EXC_RESET;
    else if (dabortReq) strobe.kind = EXC_DABT;
    else if (fiqLive)   strobe.kind = EXC_FIQ;
    else if (irqLive)   strobe.kind = EXC_IRQ;
    else if (pabtLive)  strobe.kind = EXC_PABT;
    else if (undefLive) strobe.kind = EXC_UNDEF;
    else if (swiLive)   strobe.kind = EXC_SWI;
    else                strobe.take = 1'b0;
  end

endmodule

// File: rtl/exc_entry_dp.sv
module exc_entry_dp
  import exc_entry_pkg::*;
#(
  parameter int unsigned          ADDR_W    = 32,
  parameter int unsigned          STATUS_W  = 32,
  parameter logic [ADDR_W-1:0]    HIGH_BASE = 32'hFFFF_0000
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobe_t         strobe,
  input  logic [STATUS_W-1:0] curStatus,
  input  logic [ADDR_W-1:0]   curAddr,
  input  logic [ADDR_W-1:0]   nextAddr,
  input  logic                highVec,
  input  logic                endianOnEntry,
  output logic                entryValid,
  output logic [STATUS_W-1:0] newStatus,
  output logic [STATUS_W-1:0] savedStatus,
  output logic [ADDR_W-1:0]   linkAddr,
  output logic [4:0]          targetMode,
  output logic [ADDR_W-1:0]   vectorAddr
);

  localparam logic [ADDR_W-1:0] STEP4 = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] STEP8 = ADDR_W'(8);

  logic [4:0]          modeNext;
  logic [ADDR_W-1:0]   offsetNext;
  logic [ADDR_W-1:0]   linkNext;
  logic                setF;
  logic                setA;
  logic [STATUS_W-1:0] statusNext;
  logic [ADDR_W-1:0]   vecNext;

  always_comb begin
    modeNext   = MODE_SVC;
    offsetNext = '0;
    linkNext   = curAddr + STEP4;
    setF       = 1'b0;
    setA       = 1'b1;
    unique case (strobe.kind)
      EXC_RESET: begin modeNext = MODE_SVC; offsetNext = ADDR_W'(8'h00); setF = 1'b1; end
      EXC_UNDEF: begin modeNext = MODE_UND; offsetNext = ADDR_W'(8'h04); setA = 1'b0; end
      EXC_SWI:   begin modeNext = MODE_SVC; offsetNext = ADDR_W'(8'h08); setA = 1'b0; end
      EXC_PABT:  begin modeNext = MODE_ABT; offsetNext = ADDR_W'(8'h0C); end
      EXC_DABT:  begin modeNext = MODE_ABT; offsetNext = ADDR_W'(8'h10); linkNext = curAddr + STEP8; end
      EXC_IRQ:   begin modeNext = MODE_IRQ; offsetNext = ADDR_W'(8'h18); linkNext = nextAddr + STEP4; end
      EXC_FIQ:   begin modeNext = MODE_FIQ; offsetNext = ADDR_W'(8'h1C); linkNext = nextAddr + STEP4;
                       setF = 1'b1; end
      default:   begin modeNext = MODE_SVC; end
    endcase
  end

  always_comb begin
    statusNext             = curStatus;
    statusNext[4:0]        = modeNext;
    statusNext[BIT_TSTATE] = 1'b0;
    statusNext[BIT_IMASK]  = 1'b1;
    statusNext[BIT_ENDIAN] = endianOnEntry;
    if (setF) statusNext[BIT_FMASK] = 1'b1;
    if (setA) statusNext[BIT_AMASK] = 1'b1;
    vecNext = (highVec ? HIGH_BASE : '0) | offsetNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      entryValid  <= 1'b0;
      newStatus   <= '0;
      savedStatus <= '0;
      linkAddr    <= '0;
      targetMode  <= '0;
      vectorAddr  <= '0;
    end else begin
      entryValid <= strobe.take;
      if (strobe.take) begin
        newStatus  <= statusNext;
        targetMode <= modeNext;
        vectorAddr <= vecNext;
        if (strobe.kind != EXC_RESET) begin
          savedStatus <= curStatus;
          linkAddr    <= linkNext;
        end
      end
    end
  end

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 32,
  parameter int unsigned       STATUS_W  = 32,
  parameter logic [ADDR_W-1:0] HIGH_BASE = 32'hFFFF_0000
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                resetReq,
  input  logic                undefReq,
  input  logic                swiReq,
  input  logic                pabortReq,
  input  logic                dabortReq,
  input  logic                irqReq,
  input  logic                fiqReq,
  input  logic                execValid,
  input  logic                atBoundary,
  input  logic [STATUS_W-1:0] curStatus,
  input  logic [ADDR_W-1:0]   curAddr,
  input  logic [ADDR_W-1:0]   nextAddr,
  input  logic                highVec,
  input  logic                endianOnEntry,
  output logic                entryValid,
  output logic [STATUS_W-1:0] newStatus,
  output logic [STATUS_W-1:0] savedStatus,
  output logic [ADDR_W-1:0]   linkAddr,
  output logic [4:0]          targetMode,
  output logic [ADDR_W-1:0]   vectorAddr
);

  ctrlStrobe_t strobe;

  exc_entry_sel u_sel (
    .resetReq   (resetReq),
    .undefReq   (undefReq),
    .swiReq     (swiReq),
    .pabortReq  (pabortReq),
    .dabortReq  (dabortReq),
    .irqReq     (irqReq),
    .fiqReq     (fiqReq),
    .execValid  (execValid),
    .atBoundary (atBoundary),
    .irqMasked  (curStatus[BIT_IMASK]),
    .fiqMasked  (curStatus[BIT_FMASK]),
    .strobe     (strobe)
  );

  exc_entry_dp #(
    .ADDR_W    (ADDR_W),
    .STATUS_W  (STATUS_W),
    .HIGH_BASE (HIGH_BASE)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .curStatus     (curStatus),
    .curAddr       (curAddr),
    .nextAddr      (nextAddr),
    .highVec       (highVec),
    .endianOnEntry (endianOnEntry),
    .entryValid    (entryValid),
    .newStatus     (newStatus),
    .savedStatus   (savedStatus),
    .linkAddr      (linkAddr),
    .targetMode    (targetMode),
    .vectorAddr    (vectorAddr)
  );

endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned STATUS_W = 32
) (
  input logic                clk,
  input logic                rstN,
  input logic                resetReq,
  input logic                undefReq,
  input logic                swiReq,
  input logic                pabortReq,
  input logic                dabortReq,
  input logic                irqReq,
  input logic                fiqReq,
  input logic                execValid,
  input logic                atBoundary,
  input logic [STATUS_W-1:0] curStatus,
  input logic                highVec,
  input logic                entryValid,
  input logic [STATUS_W-1:0] newStatus,
  input logic [4:0]          targetMode,
  input logic [ADDR_W-1:0]   vectorAddr
);

  logic armed;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  assert_entry_masks_R5: assert property (@(posedge clk) disable iff (!rstN)
    entryValid |-> (newStatus[7] && !newStatus[5]));

  assert_mode_legal_R4: assert property (@(posedge clk) disable iff (!rstN)
    entryValid |-> (targetMode == 5'b10011 || targetMode == 5'b11011 ||
                    targetMode == 5'b10111 || targetMode == 5'b10010 ||
                    targetMode == 5'b10001));

  assert_vec_base_R3: assert property (@(posedge clk) disable iff (!rstN)
    (armed && entryValid) |->
      (vectorAddr[ADDR_W-1:16] == ($past(highVec) ? {(ADDR_W-16){1'b1}} : {(ADDR_W-16){1'b0}})));

  assert_fmask_kept_R6: assert property (@(posedge clk) disable iff (!rstN)
    (armed && entryValid && targetMode != 5'b10011 && targetMode != 5'b10001) |->
      (newStatus[6] == $past(curStatus[6])));

  assert_fiq_taken_R10: assert property (@(posedge clk) disable iff (!rstN)
    (fiqReq && atBoundary && !curStatus[6] && !resetReq && !dabortReq) |=>
      (entryValid && targetMode == 5'b10001));

  assert_no_spurious_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!resetReq && !dabortReq && !execValid &&
     !(fiqReq && atBoundary && !curStatus[6]) &&
     !(irqReq && atBoundary && !curStatus[7])) |=> !entryValid);

  assert_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !entryValid) |-> ($stable(vectorAddr) && $stable(newStatus) && $stable(targetMode)));

endmodule

bind exc_entry_ctrl exc_entry_chk #(
  .ADDR_W   (ADDR_W),
  .STATUS_W (STATUS_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .resetReq   (resetReq),
  .undefReq   (undefReq),
  .swiReq     (swiReq),
  .pabortReq  (pabortReq),
  .dabortReq  (dabortReq),
  .irqReq     (irqReq),
  .fiqReq     (fiqReq),
  .execValid  (execValid),
  .atBoundary (atBoundary),
  .curStatus  (curStatus),
  .highVec    (highVec),
  .entryValid (entryValid),
  .newStatus  (newStatus),
  .targetMode (targetMode),
  .vectorAddr (vectorAddr)
);

// File: tb/exc_entry_ctrl_tb.sv
`timescale 1ns/1ps
module exc_entry_ctrl_tb;

  logic        clk = 1'b0;
  logic        rstN;
  logic        resetReq, undefReq, swiReq, pabortReq, dabortReq, irqReq, fiqReq;
  logic        execValid, atBoundary, highVec, endianOnEntry;
  logic [31:0] curStatus, curAddr, nextAddr;
  logic        entryValid;
  logic [31:0] newStatus, savedStatus, linkAddr, vectorAddr;
  logic [4:0]  targetMode;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 0;

  // reference state
  logic        eValid;
  logic [31:0] eNew, eSaved, eLink, eVec;
  logic [4:0]  eMode;

  always #2.5 clk = ~clk;

  exc_entry_ctrl u_dut (
    .clk(clk), .rstN(rstN), .resetReq(resetReq), .undefReq(undefReq), .swiReq(swiReq),
    .pabortReq(pabortReq), .dabortReq(dabortReq), .irqReq(irqReq), .fiqReq(fiqReq),
    .execValid(execValid), .atBoundary(atBoundary), .curStatus(curStatus),
    .curAddr(curAddr), .nextAddr(nextAddr), .highVec(highVec), .endianOnEntry(endianOnEntry),
    .entryValid(entryValid), .newStatus(newStatus), .savedStatus(savedStatus),
    .linkAddr(linkAddr), .targetMode(targetMode), .vectorAddr(vectorAddr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clearReqs();
    resetReq = 0; undefReq = 0; swiReq = 0; pabortReq = 0; dabortReq = 0;
    irqReq = 0; fiqReq = 0; execValid = 1; atBoundary = 1;
  endtask

  // Reference model: computes outputs expected after the coming edge
  task automatic modelStep();
    string which;
    bit take = 1;
    logic [31:0] s;
    which = "none";
    if (resetReq) which = "rst";
    else if (dabortReq) which = "dabt";
    else if (fiqReq && atBoundary && !curStatus[6]) which = "fiq";
    else if (irqReq && atBoundary && !curStatus[7]) which = "irq";
    else if (pabortReq && execValid) which = "pabt";
    else if (undefReq && execValid) which = "und";
    else if (swiReq && execValid) which = "swi";
    else take = 0;
    eValid = take;
    if (take) begin
      s = curStatus;
      s[5] = 0; s[7] = 1; s[9] = endianOnEntry;
      case (which)
        "rst":  begin eMode = 5'b10011; eVec = 32'h00; s[6] = 1; s[8] = 1; end
        "und":  begin eMode = 5'b11011; eVec = 32'h04; eLink = curAddr + 4; end
        "swi":  begin eMode = 5'b10011; eVec = 32'h08; eLink = curAddr + 4; end
        "pabt": begin eMode = 5'b10111; eVec = 32'h0C; eLink = curAddr + 4; s[8] = 1; end
        "dabt": begin eMode = 5'b10111; eVec = 32'h10; eLink = curAddr + 8; s[8] = 1; end
        "irq":  begin eMode = 5'b10010; eVec = 32'h18; eLink = nextAddr + 4; s[8] = 1; end
        default: begin eMode = 5'b10001; eVec = 32'h1C; eLink = nextAddr + 4; s[6] = 1; s[8] = 1; end
      endcase
      s[4:0] = eMode;
      if (highVec) eVec = eVec + 32'hFFFF_0000;
      eNew = s;
      if (which != "rst") eSaved = curStatus;
    end
  endtask

  task automatic step();
    modelStep();
    @(posedge clk);
    @(negedge clk);
    chk("R12 entryValid", {31'b0, entryValid}, {31'b0, eValid});
    chk("R4 targetMode", {27'b0, targetMode}, {27'b0, eMode});
    chk("R3 vectorAddr", vectorAddr, eVec);
    chk("R5 newStatus", newStatus, eNew);
    chk("R9 savedStatus", savedStatus, eSaved);
    chk("R8 linkAddr", linkAddr, eLink);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    rstN = 0; clearReqs(); highVec = 0; endianOnEntry = 0;
    curStatus = 32'h0000_00D3; curAddr = 32'h1000; nextAddr = 32'h1004;
    eValid = 0; eNew = 0; eSaved = 0; eLink = 0; eMode = 0; eVec = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 entryValid", {31'b0, entryValid}, 32'h0);
    chk("R1 newStatus", newStatus, 32'h0);
    chk("R1 vectorAddr", vectorAddr, 32'h0);
    chk("R1 linkAddr", linkAddr, 32'h0);
    rstN = 1;
    curStatus = 32'hA000_0010;
    step();

    // R2: precedence chain
    resetReq = 1; dabortReq = 1; fiqReq = 1; irqReq = 1; pabortReq = 1; undefReq = 1; swiReq = 1;
    step(); chk("R2 reset wins", {27'b0, targetMode}, 32'h13);
    // R9: reset entry keeps saved and link
    chk("R9 saved kept on reset", savedStatus, 32'h0);
    resetReq = 0;
    step(); chk("R2 dabt next", vectorAddr, 32'h10);
    chk("R8 dabt link", linkAddr, 32'h1008);
    dabortReq = 0;
    step(); chk("R2 fiq next", {27'b0, targetMode}, 32'h11);
    fiqReq = 0;
    step(); chk("R2 irq next", {27'b0, targetMode}, 32'h12);
    chk("R8 irq link", linkAddr, 32'h1008);
    irqReq = 0;
    step(); chk("R2 pabt next", vectorAddr, 32'h0C);
    pabortReq = 0;
    step(); chk("R2 undef next", {27'b0, targetMode}, 32'h1B);
    undefReq = 0;
    step(); chk("R2 swi last", vectorAddr, 32'h08);
    swiReq = 0;
    step();

    // R3: high vectors
    highVec = 1; fiqReq = 1;
    step(); chk("R3 high fiq vector", vectorAddr, 32'hFFFF_001C);
    fiqReq = 0; highVec = 0;

    // R6 / R7: mask bits
    curStatus = 32'h0000_0010; irqReq = 1;
    step(); chk("R6 irq keeps F clear", {31'b0, newStatus[6]}, 32'h0);
    chk("R7 irq sets A", {31'b0, newStatus[8]}, 32'h1);
    irqReq = 0; swiReq = 1; endianOnEntry = 1;
    step(); chk("R7 swi keeps A clear", {31'b0, newStatus[8]}, 32'h0);
    chk("R5 endian bit", {31'b0, newStatus[9]}, 32'h1);
    swiReq = 0; endianOnEntry = 0;

    // R10: masked / off-boundary interrupts
    curStatus = 32'h0000_0090; irqReq = 1;
    step(); chk("R10 irq masked", {31'b0, entryValid}, 32'h0);
    curStatus = 32'h0000_0010; atBoundary = 0; fiqReq = 1;
    step(); chk("R10 not at boundary", {31'b0, entryValid}, 32'h0);
    irqReq = 0; fiqReq = 0; atBoundary = 1;

    // R11: squashed fetch abort and undef
    undefReq = 1; step();
    undefReq = 0; pabortReq = 1; execValid = 0;
    step(); chk("R11 squashed pabt no entry", {31'b0, entryValid}, 32'h0);
    chk("R11 vector unchanged", vectorAddr, 32'h04);
    pabortReq = 0; execValid = 1;

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      resetReq   = ($urandom_range(0, 40) == 0);
      undefReq   = ($urandom_range(0, 6) == 0);
      swiReq     = ($urandom_range(0, 6) == 0);
      pabortReq  = ($urandom_range(0, 6) == 0);
      dabortReq  = ($urandom_range(0, 8) == 0);
      irqReq     = ($urandom_range(0, 4) == 0);
      fiqReq     = ($urandom_range(0, 5) == 0);
      execValid  = ($urandom_range(0, 3) != 0);
      atBoundary = ($urandom_range(0, 2) != 0);
      highVec    = $urandom_range(0, 1);
      endianOnEntry = $urandom_range(0, 1);
      curStatus  = $urandom;
      curAddr    = {$urandom} & 32'hFFFF_FFFC;
      nextAddr   = {$urandom} & 32'hFFFF_FFFC;
      step();
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

endmodule